// File: doc/BRIEF.md
# Biphase-Mark Stereo Audio Transmitter

This block takes stereo PCM from a three-wire serial source (bit clock, word select, data) and sends it as a self-clocking biphase-mark line. The serial pins are brought into the system clock domain and sampled on the rising bit-clock edge. A deserializer takes each sample from left-justified, I2S or right-justified framing at 16, 18, 20 or 24 bits. It left-aligns the sample into a 24-bit field and hands over a finished left/right pair.

A free-running frame timer, paced by a system-clock divider, sets the half-cell rate. At the start of every output frame the encoder takes the most recent complete pair. It builds two 32-slot subframes: a preamble, 24 audio bits LSB first, validity, a zero user bit, one channel-status bit taken from a 32-bit status word, and even parity. It then encodes them onto the line. A block-start flag marks frame 0 of every block of `FRAMES_PER_BLOCK` frames.

Top module: `bmc_audio_tx`

## Requirements
- R1: In slots 4 to 31 the line toggles at the start of every bit cell, and toggles again at mid-cell exactly when the bit is 1.
- R2: Each subframe opens with an 8-half-cell preamble which, after a low level, reads 11101000 on the left subframe of block frame 0, 11100010 on other left subframes and 11100100 on right subframes. After a high level it is inverted.
- R3: Slots 4 to 27 carry the 24-bit audio field LSB first. A sample of W bits occupies the top W bits of that field, with zeros below. Each frame carries the left and right words of one input frame, the most recent pair completed at frame start.
- R4: With `fmt_sel`=0 (left-justified), left is word select high, and the MSB is on the first bit-clock rise after a word-select change.
- R5: With `fmt_sel`=1 (I2S), left is word select low, and the MSB is on the second bit-clock rise after a word-select change.
- R6: With `fmt_sel`=2 (right-justified), left is word select high, and the LSB is on the last bit-clock rise before the next word-select change.
- R7: `width_sel` 0, 1, 2 and 3 select 16, 18, 20 and 24-bit samples.
- R8: Slot 28 carries `valid_flag` and slot 29 is always 0.
- R9: Slot 30 of both subframes of block frame f carries `chstat_word[f]` for f < 32, and 0 for later frames.
- R10: Slot 31 makes the number of ones in slots 4 to 31 even.
- R11: `block_start` is high throughout block frame 0 and low in every other frame. It changes in step with the line at the frame boundary.
- R12: During reset the line and `block_start` are low. The first frame after reset is block frame 0 and opens with the frame-0 preamble.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial bit clock, data sampled on its rising edge |
| ser_ws | input | 1 | Word select (channel framing) |
| ser_dat | input | 1 | Serial sample data, MSB first |
| fmt_sel | input | 2 | Framing: 0 left-justified, 1 I2S, 2 right-justified |
| width_sel | input | 2 | Sample width: 0=16, 1=18, 2=20, 3=24 bits |
| valid_flag | input | 1 | Value sent in the validity slot |
| chstat_word | input | 32 | Channel-status bits, bit f sent in frame f |
| bmc_out | output | 1 | Biphase-mark encoded line |
| block_start | output | 1 | High during frame 0 of each block |

## Verification
The bench sets `HALF_DIV` to 2 and keeps the default block length of 192 frames and 32 status bits. This makes one output frame 256 system clocks, matching a serial source of 64 bit clocks of four system clocks each. Well over 192 frames then fit in the run. The bench can therefore decode every frame, see the block counter wrap to a second frame-0 preamble, and watch the status bits run out after frame 31. The framing tests cover every width in left-justified mode and mixed widths in the other two modes. Their word values have bits set above the chosen width, so any truncation error shows up.

// File: rtl/bmc_tx_pkg.sv
package bmc_tx_pkg;

    localparam int SAMPLE_BITS = 24;

    typedef enum logic [1:0] {
        FMT_LEFT  = 2'd0,
        FMT_I2S   = 2'd1,
        FMT_RIGHT = 2'd2
    } fmt_e;

    // preamble half-cell patterns, first half in the MSB, valid after a low level
    localparam logic [7:0] PRE_BLOCK = 8'b1110_1000;
    localparam logic [7:0] PRE_LEFT  = 8'b1110_0010;
    localparam logic [7:0] PRE_RIGHT = 8'b1110_0100;

    function automatic logic [4:0] width_of(input logic [1:0] code);
        case (code)
            2'd0:    width_of = 5'd16;
            2'd1:    width_of = 5'd18;
            2'd2:    width_of = 5'd20;
            default: width_of = 5'd24;
        endcase
    endfunction

endpackage

// File: rtl/bmc_serial_in.sv
module bmc_serial_in
    import bmc_tx_pkg::*;
#(
    parameter int SB = SAMPLE_BITS
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ser_clk,
    input  logic          ser_ws,
    input  logic          ser_dat,
    input  logic [1:0]    fmt,
    input  logic [1:0]    width_code,
    output logic          pair_valid,
    output logic [SB-1:0] pair_left,
    output logic [SB-1:0] pair_right
);

    localparam int CW = 6;

    typedef struct packed {
        logic [1:0]    ck_sy;
        logic [1:0]    ws_sy;
        logic [1:0]    dat_sy;
        logic          ck_prev;
        logic          ws_prev;
        logic [CW-1:0] cnt;
        logic [SB-1:0] shreg;
        logic [SB-1:0] hold_l;
        logic [SB-1:0] out_l;
        logic [SB-1:0] out_r;
        logic          pv;
    } ser_state_t;

    ser_state_t q, d;

    logic          rise, bit_in, ws_now, ws_edge, left_now;
    logic          cap, cap_left;
    logic [4:0]    wlen, shamt;
    logic [CW-1:0] cnt_next, last_pos;
    logic [SB-1:0] word, aligned;

    always_comb begin
        d        = q;
        d.ck_sy  = {q.ck_sy[0], ser_clk};
        d.ws_sy  = {q.ws_sy[0], ser_ws};
        d.dat_sy = {q.dat_sy[0], ser_dat};
        d.ck_prev = q.ck_sy[1];
        d.pv     = 1'b0;

        rise     = q.ck_sy[1] & ~q.ck_prev;
        bit_in   = q.dat_sy[1];
        ws_now   = q.ws_sy[1];
        ws_edge  = ws_now ^ q.ws_prev;
        left_now = (fmt == FMT_I2S) ? ~ws_now : ws_now;

        wlen     = width_of(width_code);
        shamt    = 5'(SB) - wlen;
        last_pos = (fmt == FMT_I2S) ? {1'b0, wlen} : ({1'b0, wlen} - 6'd1);
        cnt_next = ws_edge ? '0 : ((q.cnt == {CW{1'b1}}) ? q.cnt : q.cnt + 6'd1);

        if (fmt == FMT_RIGHT) begin
            // word ended by the select change: bits already shifted in
            cap      = ws_edge;
            cap_left = ~left_now;
            word     = q.shreg;
        end else begin
            cap      = (cnt_next == last_pos);
            cap_left = left_now;
            word     = {q.shreg[SB-2:0], bit_in};
        end
        aligned = word << shamt;

        if (rise) begin
            d.ws_prev = ws_now;
            d.cnt     = cnt_next;
            d.shreg   = {q.shreg[SB-2:0], bit_in};
            if (cap) begin
                if (cap_left) begin
                    d.hold_l = aligned;
                end else begin
                    d.out_l = q.hold_l;
                    d.out_r = aligned;
                    d.pv    = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign pair_valid = q.pv;
    assign pair_left  = q.out_l;
    assign pair_right = q.out_r;

    AST_PAIR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        q.pv |=> !q.pv); // R3

    AST_PAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (q.pv && width_code == 2'd0) |-> (q.out_r[7:0] == 8'h00)); // R7

endmodule

// File: rtl/bmc_frame_timer.sv
module bmc_frame_timer #(
    parameter int HALF_DIV         = 4,
    parameter int FRAMES_PER_BLOCK = 192,
    localparam int DW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1,
    localparam int FW = $clog2(FRAMES_PER_BLOCK)
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic          tick,
    output logic          half,
    output logic [5:0]    slot,
    output logic [FW-1:0] frame
);

    typedef struct packed {
        logic [DW-1:0] div;
        logic          half;
        logic [5:0]    slot;
        logic [FW-1:0] frame;
    } tmr_state_t;

    tmr_state_t q, d;
    logic       tick_w;

    always_comb begin
        d      = q;
        tick_w = (q.div == DW'(HALF_DIV - 1));
        if (tick_w) begin
            d.div  = '0;
            d.half = ~q.half;
            if (q.half) begin
                d.slot = q.slot + 6'd1;
                if (q.slot == 6'd63) begin
                    d.frame = (q.frame == FW'(FRAMES_PER_BLOCK - 1)) ? '0 : q.frame + 1'b1;
                end
            end
        end else begin
            d.div = q.div + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign tick  = tick_w;
    assign half  = q.half;
    assign slot  = q.slot;
    assign frame = q.frame;

endmodule

// File: rtl/bmc_sub_enc.sv
module bmc_sub_enc
    import bmc_tx_pkg::*;
#(
    parameter int SB      = SAMPLE_BITS,
    parameter int CS_BITS = 32,
    parameter int FW      = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  logic               half,
    input  logic [5:0]         slot,
    input  logic [FW-1:0]      frame,
    input  logic               pair_valid,
    input  logic [SB-1:0]      pair_left,
    input  logic [SB-1:0]      pair_right,
    input  logic               valid_flag,
    input  logic [CS_BITS-1:0] chstat,
    output logic               line,
    output logic               blk
);

    typedef struct packed {
        logic [SB-1:0] pend_l;
        logic [SB-1:0] pend_r;
        logic [SB-1:0] cur_l;
        logic [SB-1:0] cur_r;
        logic          line;
        logic          ref_lvl;
        logic          blk;
        logic          started;
    } enc_state_t;

    enc_state_t q, d;

    logic [4:0]    sub_slot;
    logic          right_sub, pre_zone, pre_start, cs_bit, ref_use, pbit, dbit;
    logic [2:0]    pidx;
    logic [7:0]    pat;
    logic [SB-1:0] sample;
    logic [31:0]   sf;

    always_comb begin
        d         = q;
        sub_slot  = slot[4:0];
        right_sub = slot[5];
        pre_zone  = (sub_slot < 5'd4);
        pidx      = {sub_slot[1:0], half};
        pre_start = pre_zone && (pidx == 3'd0);

        cs_bit = 1'b0;
        for (int i = 0; i < CS_BITS; i++) begin
            if (frame == FW'(i)) cs_bit = chstat[i];
        end

        sample     = right_sub ? q.cur_r : q.cur_l;
        sf         = '0;
        sf[27:4]   = sample;
        sf[28]     = valid_flag;
        sf[29]     = 1'b0;
        sf[30]     = cs_bit;
        sf[31]     = ^sf[30:4];

        pat     = right_sub ? PRE_RIGHT : ((frame == '0) ? PRE_BLOCK : PRE_LEFT);
        pbit    = pat[3'd7 - pidx];
        ref_use = pre_start ? q.line : q.ref_lvl;
        dbit    = sf[sub_slot];

        if (pair_valid) begin
            d.pend_l = pair_left;
            d.pend_r = pair_right;
        end

        if (tick) begin
            if (pre_start && !right_sub) begin
                d.cur_l = q.pend_l;
                d.cur_r = q.pend_r;
            end
            if (pre_zone) begin
                if (pre_start) begin
                    d.ref_lvl = q.line;
                    d.started = 1'b1;
                end
                d.line = pbit ^ ref_use;
            end else begin
                d.line = half ? (dbit ? ~q.line : q.line) : ~q.line;
            end
            d.blk = (frame == '0);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign line = q.line;
    assign blk  = q.blk;

    AST_CELL_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !pre_zone && !half) |=> (q.line != $past(q.line))); // R1

    AST_PARITY_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && pre_start && q.started) |-> (q.line == q.ref_lvl)); // R10

    AST_BLK_ROSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.blk) |-> (q.line != $past(q.line))); // R11

endmodule

// File: rtl/bmc_audio_tx.sv
module bmc_audio_tx
    import bmc_tx_pkg::*;
#(
    parameter int HALF_DIV         = 4,
    parameter int FRAMES_PER_BLOCK = 192,
    parameter int CS_BITS          = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ser_clk,
    input  logic               ser_ws,
    input  logic               ser_dat,
    input  logic [1:0]         fmt_sel,
    input  logic [1:0]         width_sel,
    input  logic               valid_flag,
    input  logic [CS_BITS-1:0] chstat_word,
    output logic               bmc_out,
    output logic               block_start
);

    localparam int FW = $clog2(FRAMES_PER_BLOCK);

    logic                   pv;
    logic [SAMPLE_BITS-1:0] pl, pr;
    logic                   tick, half;
    logic [5:0]             slot;
    logic [FW-1:0]          frame;

    bmc_serial_in #(.SB(SAMPLE_BITS)) u_ser (
        .clk        (clk),
        .rst_n      (rst_n),
        .ser_clk    (ser_clk),
        .ser_ws     (ser_ws),
        .ser_dat    (ser_dat),
        .fmt        (fmt_sel),
        .width_code (width_sel),
        .pair_valid (pv),
        .pair_left  (pl),
        .pair_right (pr)
    );

    bmc_frame_timer #(
        .HALF_DIV         (HALF_DIV),
        .FRAMES_PER_BLOCK (FRAMES_PER_BLOCK)
    ) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .half  (half),
        .slot  (slot),
        .frame (frame)
    );

    bmc_sub_enc #(
        .SB      (SAMPLE_BITS),
        .CS_BITS (CS_BITS),
        .FW      (FW)
    ) u_enc (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .half       (half),
        .slot       (slot),
        .frame      (frame),
        .pair_valid (pv),
        .pair_left  (pl),
        .pair_right (pr),
        .valid_flag (valid_flag),
        .chstat     (chstat_word),
        .line       (bmc_out),
        .blk        (block_start)
    );

endmodule

// File: tb/bmc_audio_tx_tb.sv
module bmc_audio_tx_tb;

    localparam int HD   = 2;
    localparam int FPB  = 192;
    localparam int SUBC = 64 * HD;   // clocks per subframe
    localparam int FRC  = 2 * SUBC;  // clocks per frame
    localparam int NLV  = 65536;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ser_clk = 1'b0, ser_ws = 1'b0, ser_dat = 1'b0;
    logic [1:0]  fmt_sel = 2'd0, width_sel = 2'd3;
    logic        valid_flag = 1'b0;
    logic [31:0] chstat_word = 32'hA5C3_1E69;
    logic        bmc_out, block_start;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int t0 = -1;
    bit done = 1'b0;
    logic lv [NLV];
    logic bv [NLV];

    always #5 clk = ~clk;

    bmc_audio_tx #(.HALF_DIV(HD), .FRAMES_PER_BLOCK(FPB), .CS_BITS(32)) u_dut (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_ws(ser_ws), .ser_dat(ser_dat),
        .fmt_sel(fmt_sel), .width_sel(width_sel), .valid_flag(valid_flag),
        .chstat_word(chstat_word), .bmc_out(bmc_out), .block_start(block_start)
    );

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (cyc < NLV) begin
            lv[cyc] = bmc_out;
            bv[cyc] = block_start;
            if (rst_n && t0 < 0 && bmc_out) t0 = cyc;
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int wbits(input logic [1:0] c);
        return (c == 2'd0) ? 16 : (c == 2'd1) ? 18 : (c == 2'd2) ? 20 : 24;
    endfunction

    // decode subframe n from recorded half-cell levels
    task automatic decode(input int n, output logic [7:0] pre, output logic [31:0] sf,
                          output bit ok, output logic blk);
        int base = t0 + n * SUBC;
        logic prev = lv[base - 1];
        ok = 1'b1;
        sf = '0;
        for (int k = 0; k < 8; k++) pre[7-k] = lv[base + k*HD] ^ prev;
        for (int s = 4; s < 32; s++) begin
            logic h0 = lv[base + 2*s*HD];
            logic h1 = lv[base + (2*s+1)*HD];
            if (h0 == lv[base + (2*s-1)*HD]) ok = 1'b0;
            sf[s] = h0 ^ h1;
        end
        blk = bv[base];
    endtask

    task automatic send_frame(input logic [1:0] f, input int w, input logic [23:0] l, input logic [23:0] r);
        for (int p = 0; p < 64; p++) begin
            bit left = (p < 32);
            int pos = p % 32;
            logic [23:0] wd = left ? l : r;
            logic [23:0] od = left ? r : l;
            logic b = 1'b0;
            if (f == 2'd0)      b = (pos < w) ? wd[w-1-pos] : 1'b0;
            else if (f == 2'd1) b = (pos == 0) ? od[0] : ((pos <= w) ? wd[w-pos] : 1'b0);
            else                b = (pos >= 32 - w) ? wd[31-pos] : 1'b0;
            ser_clk = 1'b0;
            ser_ws  = (f == 2'd1) ? ~left : left;
            ser_dat = b;
            repeat (2) @(negedge clk);
            ser_clk = 1'b1;
            repeat (2) @(negedge clk);
        end
    endtask

    task automatic run_case(input logic [1:0] f, input logic [1:0] wc, input logic [23:0] l,
                            input logic [23:0] r, input logic v, input string req);
        int w = wbits(wc);
        int ta, fr;
        logic [7:0] pre;
        logic [31:0] sfl, sfr;
        bit okl, okr;
        logic bl;
        logic [23:0] el, er;
        fmt_sel = f; width_sel = wc; valid_flag = v;
        send_frame(f, w, l, r);
        send_frame(f, w, l, r);
        ta = cyc;
        send_frame(f, w, l, r);
        send_frame(f, w, l, r);
        fr = (ta + 16 - t0 + FRC - 1) / FRC;
        while (cyc < t0 + (fr + 1) * FRC + 8) @(negedge clk);
        decode(2*fr, pre, sfl, okl, bl);
        decode(2*fr + 1, pre, sfr, okr, bl);
        el = (l & ((24'h1 << w) - 1)) << (24 - w);
        er = (r & ((24'h1 << w) - 1)) << (24 - w);
        check(sfl[27:4] == el, {req, " R3 R7 left audio"}, {8'h0, sfl[27:4]}, {8'h0, el});
        check(sfr[27:4] == er, {req, " R3 R7 right audio"}, {8'h0, sfr[27:4]}, {8'h0, er});
        check(sfl[28] == v && sfr[28] == v, "R8 validity slot", {31'h0, sfl[28]}, {31'h0, v});
    endtask

    task automatic test_reset;
        repeat (3) @(negedge clk);
        check(bmc_out == 1'b0, "R12 line low in reset", {31'h0, bmc_out}, 32'h0);
        check(block_start == 1'b0, "R12 block flag low in reset", {31'h0, block_start}, 32'h0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic test_framing;
        run_case(2'd0, 2'd3, 24'hC3A5F1, 24'h5E6B17, 1'b0, "R4");
        run_case(2'd0, 2'd2, 24'hFA5C31, 24'h0F9E62, 1'b1, "R4");
        run_case(2'd0, 2'd1, 24'hF2B7D9, 24'h3C41A6, 1'b0, "R4");
        run_case(2'd0, 2'd0, 24'hFF8001, 24'h7FFE, 1'b0, "R4");
        run_case(2'd1, 2'd3, 24'h9D2E47, 24'h61B3C8, 1'b0, "R5");
        run_case(2'd1, 2'd0, 24'hEE1234, 24'hAB8765, 1'b1, "R5");
        run_case(2'd2, 2'd2, 24'hF8C5A3, 24'h07B2E9, 1'b0, "R6");
        run_case(2'd2, 2'd1, 24'hFC2A5D, 24'h03D5A2, 1'b0, "R6");
        run_case(2'd2, 2'd3, 24'h800001, 24'h7FFFFE, 1'b1, "R6");
    endtask

    task automatic test_stream;
        logic [7:0] pre;
        logic [31:0] sf;
        bit ok;
        logic blk;
        while (cyc < t0 + (FPB + 3) * FRC) @(negedge clk);
        for (int fr = 0; fr < FPB + 2; fr++) begin
            int bf = fr % FPB;
            for (int ch = 0; ch < 2; ch++) begin
                logic [7:0] ep = (ch == 1) ? 8'b1110_0100 : ((bf == 0) ? 8'b1110_1000 : 8'b1110_0010);
                logic ecs = (bf < 32) ? chstat_word[bf] : 1'b0;
                decode(2*fr + ch, pre, sf, ok, blk);
                check(ok, "R1 cell boundary toggle", {31'h0, ok}, 32'h1);
                check(pre == ep, (fr == 0 && ch == 0) ? "R12 R2 first preamble" : "R2 preamble",
                      {24'h0, pre}, {24'h0, ep});
                check(sf[29] == 1'b0, "R8 user slot zero", {31'h0, sf[29]}, 32'h0);
                check(sf[30] == ecs, "R9 channel status slot", {31'h0, sf[30]}, {31'h0, ecs});
                check((^sf[31:4]) == 1'b0, "R10 even parity", sf, 32'h0);
                check(blk == (bf == 0), "R11 block start flag", {31'h0, blk}, {31'h0, (bf == 0)});
            end
        end
    endtask

    initial begin
        test_reset();
        test_framing();
        test_stream();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule